// File: doc/BRIEF.md
# Card Clock Phase Select Register

This block is the timing control register of a storage-card host interface. It holds three 3-bit fields: the phase at which incoming card data is sampled, the phase at which outgoing command and data are launched, and a small clock divider value. It also holds a sticky wake-up flag. A host writes and reads the register over a simple single-cycle bus port. A second bus address reaches the sample-phase field alone, so that a tuning routine can step through sample phases without a read-modify-write.

A rate-mode input selects between two preset timing words, one for single data rate and one for double data rate. When that input changes, the matching preset is copied into the three fields. A bus write made in the same cycle takes priority over the preset. The block drives a hold-stage flag to the command path whenever the launch phase is nonzero, and a wake-up interrupt that is the flag gated by an enable input. All outputs come from registers.

Top module: `card_phase_sel`

## Requirements
- R1: While reset is asserted, every field, the wake flag, `use_hold`, `wake_irq` and `bus_rdata` are cleared to zero at the next clock edge.
- R2: A bus write to address 0 loads `bus_wdata[2:0]` into the sample phase, `bus_wdata[18:16]` into the launch phase and `bus_wdata[26:24]` into the divider. The new values appear on the field outputs after that clock edge.
- R3: Reading address 0 returns the sample phase in bits 2:0, the wake flag in bit 11, the launch phase in bits 18:16 and the divider in bits 26:24. All other bits read zero, and writes to them are ignored.
- R4: A cycle with `wake_evt` high sets the wake flag, and the flag stays set until software clears it.
- R5: A write to address 0 with bit 11 set clears the wake flag. A write with bit 11 clear leaves the flag unchanged. If `wake_evt` is high in the same cycle as a clearing write, the flag stays set.
- R6: Writing back to address 0 the word just read from it clears a set wake flag and leaves all three fields unchanged.
- R7: A bus write to address 1 loads only `bus_wdata[2:0]` into the sample phase. The other fields and the wake flag are unchanged. Reading address 1 returns the sample phase in bits 2:0 and zero in all other bits.
- R8: When `ddr_mode` differs from its value in the previous cycle, the next clock edge loads the three fields from the preset selected by the new level: `ddr_preset` when it is 1 and `sdr_preset` when it is 0. The fields are taken from the same bit positions as in R3. The preset's bit 11 and undefined bits have no effect, and the wake flag is untouched.
- R9: A bus write in the cycle of a mode change takes priority: the written value is loaded, the preset is discarded, and no load follows in later cycles.
- R10: `use_hold` is 1 exactly when the launch-phase field is nonzero, in the same cycle as the field.
- R11: `wake_irq` is 1 after a clock edge exactly when the wake flag is set and `wake_irq_en` was high at that edge.
- R12: `bus_rdata` is registered. After a clock edge it shows the addressed register as it was before that edge, so a write is not visible in the read data of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | 0 = full register, 1 = sample-phase field only |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data of the addressed register |
| ddr_mode | input | 1 | Rate mode: 1 = double data rate, 0 = single data rate |
| sdr_preset | input | DATA_W | Timing word loaded on a change to single data rate |
| ddr_preset | input | DATA_W | Timing word loaded on a change to double data rate |
| wake_evt | input | 1 | Wake-up event pulse |
| wake_irq_en | input | 1 | Wake-up interrupt enable |
| wake_irq | output | 1 | Registered wake flag AND enable |
| use_hold | output | 1 | Route command and data through the hold stage |
| sample_phase | output | FLD_W | Sample-phase field |
| drive_phase | output | FLD_W | Launch-phase field |
| clk_div | output | FLD_W | Divider field |

## Verification
Writes, presets, wake events and enable changes all take effect at the first clock edge after they are driven. The field outputs, `use_hold`, the wake flag and `wake_irq` are therefore checked at the falling edge that follows that rising edge. Read data needs the address to be held across one rising edge, and it shows the state from before that edge. The bench uses this to show that a write is not visible in the read data of its own cycle. Mode changes are driven at a falling edge and checked one edge later, both alone and together with a write. A further cycle then shows that the discarded preset never arrives.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int REG_W    = 32;
  localparam int FLD_W    = 3;
  localparam int NUM_FLD  = 3;
  localparam int FLD_SMP  = 0;
  localparam int FLD_DRV  = 1;
  localparam int FLD_DIV  = 2;
  localparam int WAKE_POS = 11;
  localparam int ADDR_MAIN = 0;
  localparam int ADDR_SMP  = 1;

  typedef enum logic [1:0] {
    SRC_KEEP,
    SRC_FULL,
    SRC_ALIAS,
    SRC_PRESET
  } fld_src_e;

  function automatic int fld_lsb(input int idx);
    case (idx)
      FLD_SMP: return 0;
      FLD_DRV: return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/cps_field.sv
module cps_field #(
  parameter int W         = 3,
  parameter bit HAS_ALIAS = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_full,
  input  logic         wr_alias,
  input  logic         ld_preset,
  input  logic [W-1:0] full_val,
  input  logic [W-1:0] alias_val,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  import cps_pkg::*;

  fld_src_e src;

  always_comb begin
    if (wr_full)                     src = SRC_FULL;
    else if (HAS_ALIAS && wr_alias)  src = SRC_ALIAS;
    else if (ld_preset)              src = SRC_PRESET;
    else                             src = SRC_KEEP;
  end

  always_comb begin
    case (src)
      SRC_FULL:   q_nxt = full_val;
      SRC_ALIAS:  q_nxt = alias_val;
      SRC_PRESET: q_nxt = preset_val;
      default:    q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  a_r1_field_reset: assert property (@(posedge clk) rst |=> (q == '0));
  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    wr_full |=> (q == $past(full_val)));
  a_r8_preset_load: assert property (@(posedge clk) disable iff (rst)
    (ld_preset && !wr_full && !(HAS_ALIAS && wr_alias)) |=> (q == $past(preset_val)));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_full && !(HAS_ALIAS && wr_alias) && !ld_preset) |=> $stable(q));
endmodule

// File: rtl/cps_wake.sv
module cps_wake (
  input  logic clk,
  input  logic rst,
  input  logic wake_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag;
    if (clr_req)  flag_nxt = 1'b0;
    if (wake_evt) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt & irq_en;
    end
  end

  a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> flag);
  a_r5_keep_unless_cleared: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);
  a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !wake_evt) |=> !flag);
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

// File: rtl/cps_readback.sv
module cps_readback #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 1,
  parameter int FLD_W   = 3,
  parameter int NUM_FLD = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_FLD-1:0][FLD_W-1:0]   fld,
  input  logic                            flag,
  output logic [DATA_W-1:0]               rdata
);
  import cps_pkg::*;

  function automatic logic [DATA_W-1:0] build_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FLD; i++)
      for (int b = 0; b < FLD_W; b++)
        m[fld_lsb(i) + b] = 1'b1;
    m[WAKE_POS] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] DEF_MASK = build_mask();

  logic [DATA_W-1:0] main_word;
  logic [DATA_W-1:0] smp_word;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    main_word = '0;
    for (int i = 0; i < NUM_FLD; i++)
      main_word[fld_lsb(i) +: FLD_W] = fld[i];
    main_word[WAKE_POS] = flag;
    smp_word = '0;
    smp_word[FLD_W-1:0] = fld[FLD_SMP];
  end

  always_comb begin
    if (addr == ADDR_W'(ADDR_MAIN))     sel_word = main_word;
    else if (addr == ADDR_W'(ADDR_SMP)) sel_word = smp_word;
    else                                sel_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel_word;
  end

  a_r3_undefined_zero: assert property (@(posedge clk) disable iff (rst)
    ((rdata & ~DEF_MASK) == '0));
  a_r1_rdata_reset: assert property (@(posedge clk) rst |=> (rdata == '0));
endmodule

// File: rtl/card_phase_sel.sv
module card_phase_sel #(
  parameter int DATA_W = cps_pkg::REG_W,
  parameter int ADDR_W = 1,
  parameter int FLD_W  = cps_pkg::FLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ddr_mode,
  input  logic [DATA_W-1:0] sdr_preset,
  input  logic [DATA_W-1:0] ddr_preset,
  input  logic              wake_evt,
  input  logic              wake_irq_en,
  output logic              wake_irq,
  output logic              use_hold,
  output logic [FLD_W-1:0]  sample_phase,
  output logic [FLD_W-1:0]  drive_phase,
  output logic [FLD_W-1:0]  clk_div
);
  import cps_pkg::*;

  localparam int DRV_LSB = fld_lsb(FLD_DRV);

  logic                          mode_q;
  logic                          mode_chg;
  logic                          wr_full;
  logic                          wr_alias;
  logic                          ld_preset;
  logic [DATA_W-1:0]             preset_sel;
  logic [NUM_FLD-1:0][FLD_W-1:0] fld_q;
  logic [NUM_FLD-1:0][FLD_W-1:0] fld_nxt;
  logic                          wake_flag;
  logic                          unused_bits;

  assign mode_chg   = (ddr_mode != mode_q);
  assign wr_full    = bus_wr && (bus_addr == ADDR_W'(ADDR_MAIN));
  assign wr_alias   = bus_wr && (bus_addr == ADDR_W'(ADDR_SMP));
  assign ld_preset  = mode_chg && !bus_wr;
  assign preset_sel = ddr_mode ? ddr_preset : sdr_preset;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= ddr_mode;
  end

  for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_fld
    localparam int LSB = fld_lsb(gi);
    cps_field #(
      .W         (FLD_W),
      .HAS_ALIAS (gi == FLD_SMP)
    ) u_fld (
      .clk        (clk),
      .rst        (rst),
      .wr_full    (wr_full),
      .wr_alias   (wr_alias),
      .ld_preset  (ld_preset),
      .full_val   (bus_wdata[LSB +: FLD_W]),
      .alias_val  (bus_wdata[FLD_W-1:0]),
      .preset_val (preset_sel[LSB +: FLD_W]),
      .q          (fld_q[gi]),
      .q_nxt      (fld_nxt[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) use_hold <= 1'b0;
    else     use_hold <= |fld_nxt[FLD_DRV];
  end

  cps_wake u_wake (
    .clk      (clk),
    .rst      (rst),
    .wake_evt (wake_evt),
    .clr_req  (wr_full && bus_wdata[WAKE_POS]),
    .irq_en   (wake_irq_en),
    .flag     (wake_flag),
    .irq      (wake_irq)
  );

  cps_readback #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .FLD_W   (FLD_W),
    .NUM_FLD (NUM_FLD)
  ) u_rb (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .fld   (fld_q),
    .flag  (wake_flag),
    .rdata (bus_rdata)
  );

  assign sample_phase = fld_q[FLD_SMP];
  assign drive_phase  = fld_q[FLD_DRV];
  assign clk_div      = fld_q[FLD_DIV];
  assign unused_bits  = ^{bus_wdata, sdr_preset, ddr_preset};

  a_r10_hold_tracks_drive: assert property (@(posedge clk) disable iff (rst)
    use_hold == (drive_phase != '0));
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && wr_full) |=> (drive_phase == $past(bus_wdata[DRV_LSB +: FLD_W])));
  a_r1_outputs_reset: assert property (@(posedge clk)
    rst |=> (!use_hold && !wake_irq));
endmodule

// File: tb/card_phase_sel_tb.sv
module card_phase_sel_tb;
  localparam logic [31:0] MASK_F = 32'h0707_0007;
  localparam logic [31:0] WBIT   = 32'h0000_0800;
  localparam logic [31:0] SDR_P  = 32'hF3F1_0806;
  localparam logic [31:0] DDR_P  = 32'h7C60_F7F1;
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'hFFFF_F7FF, 32'h0102_0003, 32'h0700_0000,
    32'h0005_0000, 32'hF8F8_F7F8, 32'h0601_0002, 32'h0304_0005
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [0:0]  bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ddr_mode = 1'b0;
  logic        wake_evt = 1'b0;
  logic        wake_irq_en = 1'b0;
  logic        wake_irq, use_hold;
  logic [2:0]  sample_phase, drive_phase, clk_div;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rd, exp_w;

  always #4 clk = ~clk;

  card_phase_sel u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ddr_mode(ddr_mode),
    .sdr_preset(SDR_P), .ddr_preset(DDR_P), .wake_evt(wake_evt),
    .wake_irq_en(wake_irq_en), .wake_irq(wake_irq), .use_hold(use_hold),
    .sample_phase(sample_phase), .drive_phase(drive_phase), .clk_div(clk_div)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic check_fields(input string req, input logic [31:0] w);
    check(req, {29'd0, sample_phase}, {29'd0, w[2:0]});
    check(req, {29'd0, drive_phase},  {29'd0, w[18:16]});
    check(req, {29'd0, clk_div},      {29'd0, w[26:24]});
    check(req, {31'd0, use_hold},     {31'd0, (w[18:16] != 3'd0)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 fields", {23'd0, sample_phase, drive_phase, clk_div}, 32'd0);
    check("R1 flags", {30'd0, use_hold, wake_irq}, 32'd0);
    bus_read(1'b0, rd);
    check("R1 rdata", rd, 32'd0);

    // R2 R3 R10: table of full writes
    for (int i = 0; i < NV; i++) begin
      bus_write(1'b0, VEC[i]);
      check_fields("R2 R10 table", VEC[i]);
      bus_read(1'b0, rd);
      check("R3 table readback", rd, VEC[i] & MASK_F);
    end

    // R4 R11: event sets flag, irq gated by enable
    bus_write(1'b0, 32'h0203_0004);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    check("R11 irq disabled", {31'd0, wake_irq}, 32'd0);
    bus_read(1'b0, rd);
    check("R4 flag set", rd, 32'h0203_0004 | WBIT);
    @(negedge clk); wake_irq_en = 1'b1;
    @(negedge clk);
    check("R11 irq enabled", {31'd0, wake_irq}, 32'd1);

    // R5: writing 0 to bit 11 keeps the flag
    bus_write(1'b0, 32'h0105_0001);
    bus_read(1'b0, rd);
    check("R5 zero write keeps", rd, 32'h0105_0001 | WBIT);

    // R6: write back the read value
    bus_write(1'b0, rd);
    check_fields("R6 fields kept", 32'h0105_0001);
    bus_read(1'b0, rd);
    check("R6 flag cleared", rd, 32'h0105_0001);
    check("R11 irq drops", {31'd0, wake_irq}, 32'd0);

    // R5: event together with clear keeps flag
    @(negedge clk);
    bus_addr = 1'b0; bus_wdata = 32'h0105_0801; bus_wr = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; wake_evt = 1'b0;
    bus_read(1'b0, rd);
    check("R5 event beats clear", rd, 32'h0105_0801);

    // R7: sample-phase alias
    bus_write(1'b1, 32'hFFFF_FFF6);
    check_fields("R7 alias write", 32'h0105_0006);
    bus_read(1'b1, rd);
    check("R7 alias read", rd, 32'h0000_0006);
    bus_read(1'b0, rd);
    check("R7 others kept", rd, 32'h0105_0806);

    // R12: read data shows pre-write state
    @(negedge clk);
    bus_addr = 1'b0; bus_wdata = 32'h0002_0003; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R12 old value", bus_rdata, 32'h0105_0806);
    bus_read(1'b0, rd);
    check("R12 new value", rd, 32'h0002_0803);

    // R8: mode change to DDR loads preset
    @(negedge clk); ddr_mode = 1'b1;
    @(negedge clk);
    exp_w = DDR_P;
    check_fields("R8 ddr preset", exp_w);
    bus_read(1'b0, rd);
    check("R8 flag untouched", rd, (DDR_P & MASK_F) | WBIT);
    // R8: back to SDR
    @(negedge clk); ddr_mode = 1'b0;
    @(negedge clk);
    check_fields("R8 sdr preset", SDR_P);

    // R9: write in the change cycle wins, no later load
    @(negedge clk);
    ddr_mode = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h0400_0002; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check_fields("R9 write wins", 32'h0400_0002);
    @(negedge clk);
    @(negedge clk);
    check_fields("R9 no late preset", 32'h0400_0002);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 re-reset", {23'd0, sample_phase, drive_phase, clk_div}, 32'd0);
    check("R1 re-reset irq", {31'd0, wake_irq}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule